// File: doc/BRIEF.md
# Selectable Machine-Cycle Tick Generator

This block turns the input clock into machine-cycle enable pulses. It has two outputs. The core tick advances the CPU. The peripheral tick advances timers, the serial port and the watchdog. Each tick is a single-clock enable pulse; it is not a derived clock. Software picks the number of clocks per machine cycle by writing a two-bit code into the upper bits of a power-management byte. The choices are 4, 64 or 1024 clocks. After reset the block runs at 4 clocks per machine cycle.

In normal and slowed (economy) operation the peripheral tick is the same pulse as the core tick. The peripherals therefore slow down together with the core. In idle the core tick stops. The peripheral tick then falls back to one pulse every 4 clocks, whatever rate is selected. A rate change never cuts a machine cycle short: a newly written code waits for the current cycle to end before it takes effect.

Top module: `mcycle_tick_gen`

## Requirements
- R1: After reset the block produces one core tick every 4 clocks, with both ticks low while reset is held.
- R2: A write (`pm_wr` high) whose `pm_wdata[7:6]` is 2'b01, 2'b10 or 2'b11 selects 4, 64 or 1024 clocks per machine cycle respectively.
- R3: A write whose `pm_wdata[7:6]` is 2'b00 leaves the current rate unchanged.
- R4: A new rate takes effect only after the machine cycle in progress ends. The interval containing the write keeps the old length, and the next interval has the new length.
- R5: Every tick is exactly one clock wide.
- R6: While `idle` is low, `periph_tick` equals `core_tick` on every clock.
- R7: While `idle` is high, `core_tick` stays low.
- R8: While `idle` is high, `periph_tick` pulses once every 4 clocks, regardless of the selected rate.
- R9: When `idle` is lowered, core ticks resume at the selected rate. Consecutive ticks are spaced by the selected number of clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pm_wr | input | 1 | Write strobe for the power-management byte |
| pm_wdata | input | 8 | Written byte; bits 7:6 carry the rate code |
| idle | input | 1 | High while the core is idle |
| core_tick | output | 1 | One-clock machine-cycle enable for the core |
| periph_tick | output | 1 | One-clock machine-cycle enable for peripherals |

## Verification
The checker assumes that the rate code only ever names one of the three legal divides, or the reserved code. Under that assumption every gap between core ticks belongs to {4, 64, 1024}. It also assumes that idle is a level held for many clocks. Its 4-clock peripheral spacing is checked only between two pulses that both fall inside one idle stretch. The stimulus drives `pm_wr` for one clock at a time, just after a tick, so each write lands inside a cycle. It raises and lowers `idle` on clock edges that are separated by hundreds of clocks.

// File: rtl/mcycle_tick_gen.sv
module mcycle_tick_gen #(
  parameter int BASE_DIV = 4,
  parameter int MID_DIV  = 64,
  parameter int SLOW_DIV = 1024
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pm_wr,
  input  logic [7:0] pm_wdata,
  input  logic       idle,
  output logic       core_tick,
  output logic       periph_tick
);
  localparam int CW = $clog2(SLOW_DIV);
  localparam int BW = $clog2(BASE_DIV);
  localparam logic [CW-1:0] LAST_BASE = CW'(BASE_DIV - 1);
  localparam logic [CW-1:0] LAST_MID  = CW'(MID_DIV - 1);
  localparam logic [CW-1:0] LAST_SLOW = CW'(SLOW_DIV - 1);
  localparam logic [BW-1:0] LAST_IDLE = BW'(BASE_DIV - 1);

  logic [1:0]    cur_code, pend_code, next_pend;
  logic [CW-1:0] cnt, last;
  logic [BW-1:0] base_cnt;
  logic          wrap;

  assign next_pend = (pm_wr && pm_wdata[7:6] != 2'b00) ? pm_wdata[7:6] : pend_code;

  always_comb begin
    case (cur_code)
      2'b10:   last = LAST_MID;
      2'b11:   last = LAST_SLOW;
      default: last = LAST_BASE;
    endcase
  end

  assign wrap = (cnt == last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      base_cnt  <= '0;
      cur_code  <= 2'b01;
      pend_code <= 2'b01;
    end else begin
      base_cnt  <= base_cnt + 1'b1;
      pend_code <= next_pend;
      if (wrap) begin
        cnt      <= '0;
        cur_code <= next_pend;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign core_tick   = rst_n && wrap && !idle;
  assign periph_tick = rst_n && (idle ? (base_cnt == LAST_IDLE) : wrap);
endmodule

// File: rtl/mcycle_tick_gen_chk.sv
module mcycle_tick_gen_chk #(
  parameter int BASE_DIV = 4,
  parameter int MID_DIV  = 64,
  parameter int SLOW_DIV = 1024
) (
  input logic clk,
  input logic rst_n,
  input logic idle,
  input logic core_tick,
  input logic periph_tick
);
  logic [31:0] core_gap, per_gap;
  logic        core_seen, per_seen;

  always_ff @(posedge clk) begin
    if (!rst_n || idle) begin
      core_gap  <= 32'd1;
      core_seen <= 1'b0;
    end else if (core_tick) begin
      core_gap  <= 32'd1;
      core_seen <= 1'b1;
    end else begin
      core_gap <= core_gap + 32'd1;
    end
    if (!rst_n || !idle) begin
      per_gap  <= 32'd1;
      per_seen <= 1'b0;
    end else if (periph_tick) begin
      per_gap  <= 32'd1;
      per_seen <= 1'b1;
    end else begin
      per_gap <= per_gap + 32'd1;
    end
  end

  AST_CORE_GAP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (core_tick && core_seen) |-> (core_gap == BASE_DIV || core_gap == MID_DIV || core_gap == SLOW_DIV)); // R2
  AST_CORE_ONE_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
    core_tick |=> !core_tick); // R5
  AST_TICKS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |-> (periph_tick == core_tick)); // R6
  AST_IDLE_NO_CORE: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !core_tick); // R7
  AST_IDLE_PERIPH_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && periph_tick && per_seen) |-> (per_gap == BASE_DIV)); // R8
endmodule

bind mcycle_tick_gen mcycle_tick_gen_chk #(
  .BASE_DIV(BASE_DIV), .MID_DIV(MID_DIV), .SLOW_DIV(SLOW_DIV)
) u_chk (
  .clk(clk), .rst_n(rst_n), .idle(idle),
  .core_tick(core_tick), .periph_tick(periph_tick)
);

// File: tb/mcycle_tick_gen_tb.sv
module mcycle_tick_gen_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pm_wr = 1'b0;
  logic [7:0] pm_wdata = 8'h00;
  logic       idle = 1'b0;
  logic       core_tick, periph_tick;
  int         checks = 0;
  int         fails = 0;
  bit         mismatch;

  always #5 clk = ~clk;

  mcycle_tick_gen u_dut (
    .clk(clk), .rst_n(rst_n), .pm_wr(pm_wr), .pm_wdata(pm_wdata),
    .idle(idle), .core_tick(core_tick), .periph_tick(periph_tick)
  );

  function automatic int div_of(input int code);
    return (code == 1) ? 4 : (code == 2) ? 64 : 1024;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic sync_tick(input bit per);
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (per ? periph_tick : core_tick) return;
    end
  endtask

  // counts clocks from the tick just seen to the next one; optional write on the first clock
  task automatic interval(input bit per, input bit do_wr, input int code, output int n);
    n = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      n++;
      if (!idle && periph_tick != core_tick) mismatch = 1'b1;
      if (n == 1) begin
        pm_wr = do_wr;
        pm_wdata = {code[1:0], 6'b101101};
      end else begin
        pm_wr = 1'b0;
      end
      if (per ? periph_tick : core_tick) begin
        pm_wr = 1'b0;
        return;
      end
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int n, cur, cnt0;
    int seq[10] = '{2, 3, 1, 3, 0, 2, 1, 0, 3, 2};
    repeat (3) @(negedge clk);
    check("R1 reset core_tick", core_tick, 0);
    check("R1 reset periph_tick", periph_tick, 0);
    rst_n = 1'b1;
    sync_tick(1'b0);
    interval(1'b0, 1'b0, 0, n);
    check("R1 default interval", n, 4);
    cur = 4;
    foreach (seq[k]) begin
      mismatch = 1'b0;
      interval(1'b0, 1'b1, seq[k], n);
      check(seq[k] == 0 ? "R3 reserved write, cycle in progress" : "R4 cycle in progress keeps old length", n, cur);
      if (seq[k] != 0) cur = div_of(seq[k]);
      for (int j = 0; j < 2; j++) begin
        interval(1'b0, 1'b0, 0, n);
        check(seq[k] == 0 ? "R3 rate unchanged after reserved code" : "R2 selected rate", n, cur);
      end
      @(negedge clk);
      check("R5 tick one clock wide", core_tick, 0);
      check("R6 periph equals core when not idle", mismatch, 0);
      sync_tick(1'b0);
    end
    // cur is 64 here
    idle = 1'b1;
    cnt0 = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (core_tick) cnt0++;
    end
    check("R7 no core tick in idle", cnt0, 0);
    sync_tick(1'b1);
    for (int j = 0; j < 3; j++) begin
      interval(1'b1, 1'b0, 0, n);
      check("R8 idle periph interval", n, 4);
    end
    @(negedge clk);
    check("R5 idle periph tick one clock wide", periph_tick, 0);
    idle = 1'b0;
    sync_tick(1'b0);
    interval(1'b0, 1'b0, 0, n);
    check("R9 resume rate after idle", n, cur);
    interval(1'b0, 1'b1, 3, n);
    check("R4 write after idle keeps old length", n, 64);
    idle = 1'b1;
    sync_tick(1'b1);
    interval(1'b1, 1'b0, 0, n);
    check("R8 idle periph interval at slow rate", n, 4);
    idle = 1'b0;
    sync_tick(1'b0);
    interval(1'b0, 1'b0, 0, n);
    check("R9 resume slow rate", n, 1024);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule